// File: doc/BRIEF.md
# Bus Message Timing Supervisor

This block supplies the interval timing for a dual-redundant command/response serial bus controller. It has three independent timers: an intermessage gap timer that decides when the next controller message may begin, a response timer that waits for a remote terminal's status word after a command, and a per-channel transmitter watchdog that blocks a transmission that runs too long. The block does no Manchester coding, no word framing and no protocol sequencing. It takes single-cycle event strobes from the encoder and decoder and returns flags.

All intervals are calibrated in microseconds. The clock may run at 16 MHz or, with `slow_clk` set, at 12 MHz. Each timer has its own prescaler. That prescaler is cleared when its timer is armed, so every interval is an exact number of clocks counted from the arming edge. The response timer counts half-microseconds, because its four windows fall on half-microsecond values. It starts at the mid-parity crossing of a command, including the transmit command of a terminal-to-terminal transfer. The mid-sync crossing of the answering status word cancels it.

Top module: `bus_timing_supervisor`

## Requirements
- R1: After reset, `gap_done`, `rsp_timeout` and both `tx_inhibit` bits are 0.
- R2: With `slow_clk`=0, `gap_done` is high for exactly one clock. It rises `gap_us`×16 clocks after the clock edge that captures `gap_start`.
- R3: With `slow_clk`=1, one microsecond is 12 clocks for the gap timer and the watchdog, and one half-microsecond is 6 clocks for the response timer.
- R4: A `gap_us` value of 0 gives the minimum gap of 4 µs rather than no gap.
- R5: `gap_us` is captured on the `gap_start` edge, so later changes do not alter a running gap. A new `gap_start` restarts the gap from its own edge, and the earlier gap then produces no pulse.
- R6: `rsp_sel` chooses the response window: 0 = 18.5 µs (37 half-µs), 1 = 22.5 µs (45), 2 = 50.5 µs (101), 3 = 128 µs (256). `rsp_timeout` is high for one clock. It rises that many half-µs after the edge that captures `cmd_midpar`, which is 8 clocks per half-µs at 16 MHz.
- R7: A `sts_midsync` strobe while the response window is open closes the window, and no `rsp_timeout` follows. A `sts_midsync` strobe while the window is closed has no effect.
- R8: A `cmd_midpar` strobe while the window is open restarts the full window from the new edge.
- R9: When `tx_active[i]` stays high for 668 µs of clock edges, counted from the first edge that samples it high, `tx_inhibit[i]` is set. A low sample resets the count. Each channel is independent of the other.
- R10: `tx_inhibit[i]` stays set after the transmission ends. It clears only on `wdog_clr[i]` or on reset. The clear also restarts the count, so a transmission that is still active trips again after another full 668 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 MHz or 12 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | 1 selects 12 clocks per µs, 0 selects 16 |
| gap_start | input | 1 | Strobe that arms the intermessage gap |
| gap_us | input | 16 | Gap length in µs; 0 selects the minimum gap |
| gap_done | output | 1 | One-clock pulse when the gap has elapsed |
| cmd_midpar | input | 1 | Strobe at mid-parity of a command word; opens the response window |
| sts_midsync | input | 1 | Strobe at mid-sync of a received status word |
| rsp_sel | input | 2 | Response window select (see R6) |
| rsp_timeout | output | 1 | One-clock no-response pulse |
| tx_active | input | 2 | Per-channel transmitter-on level |
| wdog_clr | input | 2 | Per-channel clear of the watchdog inhibit |
| tx_inhibit | output | 2 | Sticky per-channel transmitter inhibit |

## Verification
Each timer's state shows at the ports only through its pulse, so a wrong count or a wrong prescaler phase appears as a pulse that comes one or more clocks early or late. The bench therefore watches every edge of the interval and checks the exact edge where the pulse must occur. A window that fails to close after a status strobe shows as a stray `rsp_timeout` within 18.5 µs. A stale gap target shows at the old expiry time. A watchdog count that is not reset shows as an early inhibit, and a clear that is lost shows at once on `tx_inhibit`.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        RSP_WIN_SHORT = 2'b00,
        RSP_WIN_MED   = 2'b01,
        RSP_WIN_LONG  = 2'b10,
        RSP_WIN_XLONG = 2'b11
    } rsp_win_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/bt_tick_div.sv
module bt_tick_div #(
    parameter int FAST_DIV = 16,
    parameter int SLOW_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int MAXD = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int PW   = (MAXD > 2) ? $clog2(MAXD) : 1;
    localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
    localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim   = slow ? SLOW_LIM : FAST_LIM;
        tick  = en && !clr && (pre_q >= lim);
        pre_d = pre_q;
        if (clr) begin
            pre_d = '0;
        end else if (en) begin
            pre_d = tick ? '0 : pre_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3: a tick never repeats on the next clock while the divider runs on
    p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en) |=> !tick);

endmodule

// File: rtl/bt_interval_timer.sv
module bt_interval_timer #(
    parameter int CNT_W    = 16,
    parameter int FAST_DIV = 16,
    parameter int SLOW_DIV = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow,
    input  logic             start,
    input  logic             cancel,
    input  logic [CNT_W-1:0] target,
    output logic             expire
);
    typedef struct packed {
        logic             active;
        logic             expire;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tgt;
    } tmr_s;

    tmr_s st_d, st_q;
    logic tick;

    bt_tick_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .slow  (slow),
        .clr   (start),
        .en    (st_q.active && !cancel),
        .tick  (tick)
    );

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.tgt    = target;
        end else if (cancel && st_q.active) begin
            st_d.active = 1'b0;
        end else if (st_q.active && tick) begin
            if (st_q.cnt == st_q.tgt - CNT_W'(1)) begin
                st_d.active = 1'b0;
                st_d.expire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = st_q.expire;

    // R2: an expiry pulse only follows a running interval
    p_expire_from_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.expire |-> $past(st_q.active));

    // R7: a cancel of a running interval yields no pulse
    p_cancel_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && st_q.active && !start) |=> !st_q.expire);

    // R8: arming restarts from a zero count
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.active && st_q.cnt == '0 && !st_q.expire));

    // R4: the interval length presented on arming is never zero
    p_target_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (target != '0));

endmodule

// File: rtl/bt_tx_watchdog.sv
module bt_tx_watchdog #(
    parameter int LIMIT_US = 668,
    parameter int FAST_DIV = 16,
    parameter int SLOW_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    input  logic tx_on,
    input  logic clr,
    output logic inhibit
);
    localparam int CW = $clog2(LIMIT_US + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT_US - 1);

    typedef struct packed {
        logic          inh;
        logic [CW-1:0] cnt;
    } wd_s;

    wd_s  st_d, st_q;
    logic tick;

    bt_tick_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .slow  (slow),
        .clr   (clr || !tx_on),
        .en    (tx_on),
        .tick  (tick)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.inh = 1'b0;
            st_d.cnt = '0;
        end else if (!tx_on) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.inh = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign inhibit = st_q.inh;

    // R9: the inhibit only rises out of an active transmission
    p_trip_needs_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.inh) |-> $past(tx_on));

    // R10: the inhibit holds until cleared
    p_inhibit_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.inh && !clr) |=> st_q.inh);

    // R10: a clear drops the inhibit on the next edge
    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.inh);

endmodule

// File: rtl/bus_timing_supervisor.sv
module bus_timing_supervisor #(
    parameter int FAST_DIV   = 16,
    parameter int SLOW_DIV   = 12,
    parameter int GAP_W      = 16,
    parameter int GAP_MIN_US = 4,
    parameter int RSP_HALF_0 = 37,
    parameter int RSP_HALF_1 = 45,
    parameter int RSP_HALF_2 = 101,
    parameter int RSP_HALF_3 = 256,
    parameter int WDOG_US    = 668,
    parameter int CH_N       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_clk,
    input  logic             gap_start,
    input  logic [GAP_W-1:0] gap_us,
    output logic             gap_done,
    input  logic             cmd_midpar,
    input  logic             sts_midsync,
    input  logic [1:0]       rsp_sel,
    output logic             rsp_timeout,
    input  logic [CH_N-1:0]  tx_active,
    input  logic [CH_N-1:0]  wdog_clr,
    output logic [CH_N-1:0]  tx_inhibit
);
    import bt_pkg::*;

    localparam int RSP_MAX = max4(RSP_HALF_0, RSP_HALF_1, RSP_HALF_2, RSP_HALF_3);
    localparam int RSP_CW  = $clog2(RSP_MAX + 1);
    localparam int HALF_FAST = FAST_DIV / 2;
    localparam int HALF_SLOW = SLOW_DIV / 2;

    logic [GAP_W-1:0]  gap_tgt;
    logic [RSP_CW-1:0] rsp_tgt;

    always_comb begin
        gap_tgt = (gap_us == '0) ? GAP_W'(GAP_MIN_US) : gap_us;
        case (rsp_win_e'(rsp_sel))
            RSP_WIN_SHORT: rsp_tgt = RSP_CW'(RSP_HALF_0);
            RSP_WIN_MED:   rsp_tgt = RSP_CW'(RSP_HALF_1);
            RSP_WIN_LONG:  rsp_tgt = RSP_CW'(RSP_HALF_2);
            default:       rsp_tgt = RSP_CW'(RSP_HALF_3);
        endcase
    end

    bt_interval_timer #(.CNT_W(GAP_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .slow   (slow_clk),
        .start  (gap_start),
        .cancel (1'b0),
        .target (gap_tgt),
        .expire (gap_done)
    );

    bt_interval_timer #(.CNT_W(RSP_CW), .FAST_DIV(HALF_FAST), .SLOW_DIV(HALF_SLOW)) u_rsp (
        .clk    (clk),
        .rst_n  (rst_n),
        .slow   (slow_clk),
        .start  (cmd_midpar),
        .cancel (sts_midsync),
        .target (rsp_tgt),
        .expire (rsp_timeout)
    );

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_wdog
        bt_tx_watchdog #(.LIMIT_US(WDOG_US), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_wd (
            .clk     (clk),
            .rst_n   (rst_n),
            .slow    (slow_clk),
            .tx_on   (tx_active[ch]),
            .clr     (wdog_clr[ch]),
            .inhibit (tx_inhibit[ch])
        );
    end

    // R6: a no-response pulse never lasts two clocks
    p_timeout_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |=> !rsp_timeout);

    // R2: a gap-done pulse never lasts two clocks
    p_gap_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_done |=> !gap_done);

endmodule

// File: tb/bus_timing_supervisor_test.sv
module bus_timing_supervisor_test;

    localparam int WD_CLKS = 668 * 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_clk = 1'b0;
    logic       gap_start = 1'b0;
    logic [15:0] gap_us = '0;
    logic       gap_done;
    logic       cmd_midpar = 1'b0;
    logic       sts_midsync = 1'b0;
    logic [1:0] rsp_sel = 2'd0;
    logic       rsp_timeout;
    logic [1:0] tx_active = '0;
    logic [1:0] wdog_clr = '0;
    logic [1:0] tx_inhibit;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    bus_timing_supervisor uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_clk   (slow_clk),
        .gap_start  (gap_start),
        .gap_us     (gap_us),
        .gap_done   (gap_done),
        .cmd_midpar (cmd_midpar),
        .sts_midsync(sts_midsync),
        .rsp_sel    (rsp_sel),
        .rsp_timeout(rsp_timeout),
        .tx_active  (tx_active),
        .wdog_clr   (wdog_clr),
        .tx_inhibit (tx_inhibit)
    );

    function automatic logic obs(int w);
        case (w)
            0:       return gap_done;
            1:       return rsp_timeout;
            2:       return tx_inhibit[0];
            default: return tx_inhibit[1];
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // waits n edges; output w must stay low before edge n and be high after it
    task automatic expect_event(int n, int w, bit pulse, string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < n - 1; i++) begin
            @(posedge clk); #1;
            if (obs(w)) seen = 1'b1;
        end
        check(!seen, req, "no early event", int'(seen), 0);
        @(posedge clk); #1;
        check(obs(w) == 1'b1, req, "event at exact edge", int'(obs(w)), 1);
        if (pulse) begin
            @(posedge clk); #1;
            check(obs(w) == 1'b0, req, "pulse lasts one clock", int'(obs(w)), 0);
        end
    endtask

    task automatic expect_quiet(int n, int w, string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (obs(w)) seen = 1'b1;
        end
        check(!seen, req, "no event in window", int'(seen), 0);
    endtask

    task automatic strobe_gap(int us);
        @(negedge clk); gap_us = 16'(us); gap_start = 1'b1;
        @(posedge clk); #1 gap_start = 1'b0;
    endtask

    task automatic strobe_cmd(int sel);
        @(negedge clk); rsp_sel = 2'(sel); cmd_midpar = 1'b1;
        @(posedge clk); #1 cmd_midpar = 1'b0;
    endtask

    task automatic strobe_sts();
        @(negedge clk); sts_midsync = 1'b1;
        @(posedge clk); #1 sts_midsync = 1'b0;
    endtask

    task automatic t_reset();
        check(gap_done == 1'b0, "R1", "gap_done after reset", int'(gap_done), 0);
        check(rsp_timeout == 1'b0, "R1", "rsp_timeout after reset", int'(rsp_timeout), 0);
        check(tx_inhibit == 2'b00, "R1", "tx_inhibit after reset", int'(tx_inhibit), 0);
    endtask

    task automatic t_gap_fast();
        slow_clk = 1'b0;
        strobe_gap(5);
        expect_event(5 * 16, 0, 1'b1, "R2");
    endtask

    task automatic t_slow_mode();
        slow_clk = 1'b1;
        strobe_gap(7);
        expect_event(7 * 12, 0, 1'b1, "R3");
        strobe_cmd(0);
        expect_event(37 * 6, 1, 1'b1, "R3");
        slow_clk = 1'b0;
    endtask

    task automatic t_gap_zero();
        strobe_gap(0);
        expect_event(4 * 16, 0, 1'b1, "R4");
    endtask

    task automatic t_gap_sampled();
        strobe_gap(10);
        repeat (20) @(posedge clk);
        #1 gap_us = 16'd2;
        expect_event(160 - 20, 0, 1'b1, "R5");
        strobe_gap(10);
        repeat (49) @(posedge clk);
        #1;
        strobe_gap(3);
        expect_event(48, 0, 1'b1, "R5");
        expect_quiet(150, 0, "R5");
    endtask

    task automatic t_rsp_windows();
        strobe_cmd(0); expect_event(37 * 8, 1, 1'b1, "R6");
        strobe_cmd(1); expect_event(45 * 8, 1, 1'b1, "R6");
        strobe_cmd(2); expect_event(101 * 8, 1, 1'b1, "R6");
        strobe_cmd(3); expect_event(256 * 8, 1, 1'b1, "R6");
    endtask

    task automatic t_rsp_cancel();
        strobe_cmd(0);
        repeat (99) @(posedge clk);
        #1;
        strobe_sts();
        expect_quiet(400, 1, "R7");
        strobe_sts();
        expect_quiet(50, 1, "R7");
        strobe_cmd(0);
        expect_event(37 * 8, 1, 1'b1, "R7");
    endtask

    task automatic t_rsp_restart();
        strobe_cmd(0);
        repeat (99) @(posedge clk);
        #1;
        strobe_cmd(0);
        expect_event(37 * 8, 1, 1'b1, "R8");
    endtask

    task automatic t_wdog_trip();
        @(negedge clk); tx_active[0] = 1'b1;
        expect_event(WD_CLKS, 2, 1'b0, "R9");
        check(tx_inhibit[1] == 1'b0, "R9", "other channel untouched", int'(tx_inhibit[1]), 0);
        @(negedge clk); tx_active[0] = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        check(tx_inhibit[0] == 1'b1, "R10", "inhibit held after tx ends", int'(tx_inhibit[0]), 1);
        @(negedge clk); wdog_clr[0] = 1'b1;
        @(posedge clk); #1 wdog_clr[0] = 1'b0;
        check(tx_inhibit[0] == 1'b0, "R10", "inhibit cleared", int'(tx_inhibit[0]), 0);
    endtask

    task automatic t_wdog_clear_active();
        @(negedge clk); tx_active[0] = 1'b1;
        expect_event(WD_CLKS, 2, 1'b0, "R10");
        @(negedge clk); wdog_clr[0] = 1'b1;
        @(posedge clk); #1 wdog_clr[0] = 1'b0;
        check(tx_inhibit[0] == 1'b0, "R10", "clear while transmitting", int'(tx_inhibit[0]), 0);
        expect_event(WD_CLKS, 2, 1'b0, "R10");
        @(negedge clk); tx_active[0] = 1'b0; wdog_clr[0] = 1'b1;
        @(posedge clk); #1 wdog_clr[0] = 1'b0;
    endtask

    task automatic t_wdog_gap_resets();
        @(negedge clk); tx_active[1] = 1'b1;
        repeat (5000) @(posedge clk);
        @(negedge clk); tx_active[1] = 1'b0;
        @(negedge clk); tx_active[1] = 1'b1;
        expect_event(WD_CLKS, 3, 1'b0, "R9");
        check(tx_inhibit[0] == 1'b0, "R9", "channel 0 stays clear", int'(tx_inhibit[0]), 0);
        @(negedge clk); tx_active[1] = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_gap_fast();
        t_slow_mode();
        t_gap_zero();
        t_gap_sampled();
        t_rsp_windows();
        t_rsp_cancel();
        t_rsp_restart();
        t_wdog_trip();
        t_wdog_clear_active();
        t_wdog_gap_resets();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 150000, 0);
        report();
    end

endmodule